// File: doc/BRIEF.md
# Cascaded Square-Wave Clock Divider

This block derives three slower square waves from one fast oscillator clock. A chain of three modulo counters runs on that clock. The first counter counts every oscillator cycle. Each later counter counts only on cycles where the stage before it reaches its last value. When a counter wraps, it raises a strobe for exactly one oscillator period. A toggle register then turns each strobe into a 50% duty-cycle output at half the strobe rate.

The counters chain through count enables, not through derived clocks. Every register therefore shares the oscillator clock, and every output changes on its rising edge. The ratios N1, N2 and N3 are fixed when the design is elaborated. Tap A has a period of 2·N1 oscillator cycles. Tap B has a period of 2·N1·N2 cycles, and tap C has a period of 2·N1·N2·N3 cycles. The default ratios 625, 16 and 24 turn a 36 MHz oscillator into 28.8 kHz, 1.8 kHz and 75 Hz.

Top module: `clkgen_cascade`

## Requirements
- R1: After any rising edge at which `rst_n` is low, all six outputs are 0 and every counter restarts from zero.
- R2: Let k be the number of rising edges with `rst_n` high since the last reset edge. `tap_a_stb` is high exactly when k mod N1 equals N1-1, so it lasts one cycle and repeats every N1 cycles.
- R3: `tap_a_sq` equals floor(k/N1) mod 2. It flips on the edge that ends each `tap_a_stb` pulse, starts low, and has a period of 2·N1 with equal high and low times.
- R4: `tap_b_stb` is high exactly when k mod (N1·N2) equals N1·N2-1. It is only ever high together with `tap_a_stb`.
- R5: `tap_b_sq` equals floor(k/(N1·N2)) mod 2, which gives a period of 2·N1·N2 with equal halves.
- R6: `tap_c_stb` is high exactly when k mod (N1·N2·N3) equals N1·N2·N3-1. It is only ever high together with `tap_b_stb`.
- R7: `tap_c_sq` equals floor(k/(N1·N2·N3)) mod 2, which gives a period of 2·N1·N2·N3 with equal halves.
- R8: A later stage holds its count on every cycle where the strobe of the stage before it is low. Every ratio works down to the minimum of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; the only clock in the block |
| rst_n | input | 1 | Synchronous reset, active low |
| tap_a_stb | output | 1 | One-cycle strobe every N1 cycles |
| tap_a_sq | output | 1 | Square wave, period 2·N1 |
| tap_b_stb | output | 1 | One-cycle strobe every N1·N2 cycles |
| tap_b_sq | output | 1 | Square wave, period 2·N1·N2 |
| tap_c_stb | output | 1 | One-cycle strobe every N1·N2·N3 cycles |
| tap_c_sq | output | 1 | Square wave, period 2·N1·N2·N3 |

## Verification
The bench counts edges since reset. Every cycle, it predicts all six outputs from that count and compares them with the design. This comparison catches any error in phase, period or duty cycle.

Reset pulses arrive at random times, including in the middle of a period. A counter that failed to clear would show the wrong phase from then on.

A second instance uses the minimum ratio of 2 in every stage. This is where an off-by-one in the wrap value, or a stage that counts while its enable is low, gives the wrong tap periods most quickly. A wrong wrap value shows up as a period of 2·(N±1).

// File: rtl/clkgen_pkg.sv
// Shared constants and helpers for the cascaded divider.
// Assumes ratios are elaboration-time values of at least 2.
package clkgen_pkg;

    localparam int unsigned NUM_TAPS = 3;

    // Width of a counter that holds 0..n-1 (never below one bit).
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/clkgen_mod_stage.sv
// One modulo-N counting stage. It advances only while en is high and
// wraps after N-1. tc is high for the single enabled cycle in which the
// count sits at N-1. Assumes N >= 2 and one clock for the whole block.
module clkgen_mod_stage #(
    parameter int unsigned N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tc
);
    import clkgen_pkg::*;

    localparam int unsigned W = cnt_width(N);
    localparam logic [W-1:0] LAST = W'(N - 1);

    logic [W-1:0] cnt;
    logic         at_last;

    assign at_last = (cnt == LAST);
    assign tc      = en && at_last;

    // Count enabled cycles modulo N, clearing on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= at_last ? '0 : cnt + 1'b1;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);                                                    // R8
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt));                                           // R8
    AST_TC_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);                                                     // R2
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> (cnt == '0));                                             // R2

endmodule

// File: rtl/clkgen_toggle_ff.sv
// Toggle register that squares a strobe. It flips once per tick, so its
// output has half the strobe rate and a 50% duty cycle when the ticks
// are evenly spaced. Reset forces the output low.
module clkgen_toggle_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic q
);

    // Flip the output on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (tick) begin
            q <= ~q;
        end
    end

    AST_FLIP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (q != $past(q)));                                       // R3
    AST_STEADY_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(q));                                           // R3

endmodule

// File: rtl/clkgen_cascade.sv
// Top of the cascaded divider. Three modulo stages are chained by
// terminal-count enables, and each strobe feeds a toggle register.
// Every register uses osc_clk. Assumes N1, N2 and N3 are all >= 2.
module clkgen_cascade #(
    parameter int unsigned N1 = 625,
    parameter int unsigned N2 = 16,
    parameter int unsigned N3 = 24
) (
    input  logic osc_clk,
    input  logic rst_n,
    output logic tap_a_stb,
    output logic tap_a_sq,
    output logic tap_b_stb,
    output logic tap_b_sq,
    output logic tap_c_stb,
    output logic tap_c_sq
);
    import clkgen_pkg::*;

    logic [NUM_TAPS-1:0] tick;
    logic [NUM_TAPS-1:0] sq;

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        localparam int unsigned NI = (i == 0) ? N1 : ((i == 1) ? N2 : N3);
        logic en;

        if (i == 0) begin : g_first
            assign en = 1'b1;
        end else begin : g_chain
            assign en = tick[i-1];
        end

        clkgen_mod_stage #(.N(NI)) u_stage (
            .clk   (osc_clk),
            .rst_n (rst_n),
            .en    (en),
            .tc    (tick[i])
        );

        clkgen_toggle_ff u_sq (
            .clk   (osc_clk),
            .rst_n (rst_n),
            .tick  (tick[i]),
            .q     (sq[i])
        );
    end

    assign tap_a_stb = tick[0];
    assign tap_b_stb = tick[1];
    assign tap_c_stb = tick[2];
    assign tap_a_sq  = sq[0];
    assign tap_b_sq  = sq[1];
    assign tap_c_sq  = sq[2];

    AST_RESET_CLEARS: assert property (@(posedge osc_clk)
        !rst_n |=> (!tap_a_sq && !tap_b_sq && !tap_c_sq && !tap_a_stb));  // R1
    AST_B_NESTED_IN_A: assert property (@(posedge osc_clk) disable iff (!rst_n)
        tap_b_stb |-> tap_a_stb);                                         // R4
    AST_C_NESTED_IN_B: assert property (@(posedge osc_clk) disable iff (!rst_n)
        tap_c_stb |-> tap_b_stb);                                         // R6

endmodule

// File: tb/tb_clkgen_cascade.sv
`timescale 1ns/1ps
module tb_clkgen_cascade;

    localparam int unsigned A1 = 5;
    localparam int unsigned A2 = 3;
    localparam int unsigned A3 = 4;
    localparam int unsigned M  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic a_stb, a_sq, b_stb, b_sq, c_stb, c_sq;
    logic m_a_stb, m_a_sq, m_b_stb, m_b_sq, m_c_stb, m_c_sq;

    clkgen_cascade #(.N1(A1), .N2(A2), .N3(A3)) dut (
        .osc_clk(clk), .rst_n(rst_n),
        .tap_a_stb(a_stb), .tap_a_sq(a_sq),
        .tap_b_stb(b_stb), .tap_b_sq(b_sq),
        .tap_c_stb(c_stb), .tap_c_sq(c_sq));

    clkgen_cascade #(.N1(M), .N2(M), .N3(M)) dut_min (
        .osc_clk(clk), .rst_n(rst_n),
        .tap_a_stb(m_a_stb), .tap_a_sq(m_a_sq),
        .tap_b_stb(m_b_stb), .tap_b_sq(m_b_sq),
        .tap_c_stb(m_c_stb), .tap_c_sq(m_c_sq));

    int unsigned k = 0;
    int vectors = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference edge count since the last reset edge.
    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
    end

    // Expected {c_sq, c_stb, b_sq, b_stb, a_sq, a_stb} from the edge count.
    function automatic logic [5:0] expect_taps(input int unsigned cnt,
            input int unsigned n1, input int unsigned n2, input int unsigned n3);
        int unsigned pa = n1;
        int unsigned pb = n1 * n2;
        int unsigned pc = n1 * n2 * n3;
        logic [5:0] e;
        e[0] = (cnt % pa) == pa - 1;
        e[1] = ((cnt / pa) % 2) == 1;
        e[2] = (cnt % pb) == pb - 1;
        e[3] = ((cnt / pb) % 2) == 1;
        e[4] = (cnt % pc) == pc - 1;
        e[5] = ((cnt / pc) % 2) == 1;
        return e;
    endfunction

    task automatic cmp(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at k=%0d: actual=%b expected=%b", tag, k, act, exp);
        end
    endtask

    task automatic check_all(input bit in_reset);
        logic [5:0] e;
        logic [5:0] em;
        if (in_reset) begin
            e = '0;
            em = '0;
        end else begin
            e  = expect_taps(k, A1, A2, A3);
            em = expect_taps(k, M, M, M);
        end
        cmp(in_reset ? "R1 a_stb" : "R2 a_stb", a_stb, e[0]);
        cmp(in_reset ? "R1 a_sq"  : "R3 a_sq",  a_sq,  e[1]);
        cmp(in_reset ? "R1 b_stb" : "R4 b_stb", b_stb, e[2]);
        cmp(in_reset ? "R1 b_sq"  : "R5 b_sq",  b_sq,  e[3]);
        cmp(in_reset ? "R1 c_stb" : "R6 c_stb", c_stb, e[4]);
        cmp(in_reset ? "R1 c_sq"  : "R7 c_sq",  c_sq,  e[5]);
        // R8: minimum ratios expose any stage that counts while idle
        cmp("R8 min a_stb", m_a_stb, em[0]);
        cmp("R8 min a_sq",  m_a_sq,  em[1]);
        cmp("R8 min b_stb", m_b_stb, em[2]);
        cmp("R8 min b_sq",  m_b_sq,  em[3]);
        cmp("R8 min c_stb", m_c_stb, em[4]);
        cmp("R8 min c_sq",  m_c_sq,  em[5]);
    endtask

    initial begin : main
        bit in_reset;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all(1'b1);                      // R1 reset state
        rst_n = 1'b1;
        // Directed: three full tap C periods with no interruption.
        for (int i = 0; i < 3 * 2 * A1 * A2 * A3; i++) begin
            @(negedge clk);
            check_all(1'b0);
        end
        // Random: reset pulses at random points, including mid-period.
        in_reset = 1'b0;
        for (int i = 0; i < 8000; i++) begin
            @(negedge clk);
            check_all(in_reset);
            if (!in_reset && ($urandom % 400) == 0) begin
                rst_n = 1'b0;
            end else if (in_reset && ($urandom % 2) == 0) begin
                rst_n = 1'b1;
            end
            // The next edge samples rst_n; the next check sees the result.
            in_reset = !rst_n;
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : watchdog
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule